// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequencer

This block is a serial-flash controller core in which no flash command is fixed in hardware. Software stores short programs in an instruction table, then starts one program by writing a trigger register. The engine walks the program and drives a single-lane SPI master. Each step of a program does one of four things: it sends a command byte, sends address bits taken from an address register, runs idle dummy clocks, or moves data bytes. Write data comes from a transmit word queue, and read data goes into a receive word buffer that software reads by index.

The table is guarded by a key lock. While it is locked, writes to it have no effect. A busy bit and a queue-full bit report progress. A sticky done flag, cleared by writing one to it, can raise an interrupt. Each table entry is 32 bits wide and holds two 16-bit instructions. Each instruction has three fields: a 6-bit opcode in the upper bits, a 2-bit pad code in the middle, and an 8-bit operand in the low byte.

The engine is a four-state machine:
- IDLE: chip select high, waiting for a trigger.
- DECODE: fetches the next instruction and loads the shift register.
- SHIFT: clocks the bits of the current instruction.
- FINISH: releases chip select and sets the done flag.

The transitions are:
- IDLE to DECODE on an accepted trigger.
- DECODE to SHIFT when the instruction has a nonzero bit count.
- DECODE to DECODE when the instruction has a zero bit count; the instruction is skipped.
- DECODE to FINISH when the program has ended.
- SHIFT to DECODE after the falling clock edge of the instruction's last bit.
- FINISH to IDLE after one cycle.

Top module: `fs_top`

## Requirements
- R1: After reset the bus reads as follows, with the SPI clock low and chip select high:
  - status (byte offset 0x0C) reads 0;
  - flag (0x10) reads 0;
  - receive status (0x18) reads 0;
  - the interrupt is low;
  - every table word (0x100 + 4*i) reads 0;
  - the table is locked.
- R2: A write to a table word takes effect only while the table is unlocked. The table unlocks when the key word 0x5AF05AF0 is written to offset 0x20 and the very next bus write puts 2 into lock control (0x24). Key followed by 1 locks it. A wrong key, or any other write in between, cancels the key.
- R3: A trigger write to offset 0x04 selects program number bits 27:24 and byte count bits 7:0. The program runs table words 4*program to 4*program+3. Within each word the instruction in bits 15:0 runs before the one in bits 31:16. An instruction has opcode in bits 15:10, pad in bits 9:8 (unused) and operand in bits 7:0.
- R4: Opcode 1 sends its operand as 8 bits, most significant bit first, in SPI mode 0. The clock idles low, data changes after the falling edge and is sampled on the rising edge. The clock high and low phases each last CLK_DIV system clocks.
- R5: Opcode 2 sends the low n bits of the address register (offset 0x08), most significant first. Here n is the operand, limited to 32.
- R6: Opcode 3 runs operand clock cycles with the data-out line held low.
- R7: Opcode 8 sends data bytes from transmit words written at offset 0x1C, each word's most significant byte first.
  - The byte count is the trigger count if nonzero, otherwise the operand.
  - The queue holds TX_WORDS (16) words; status bit 27 is set while it is full.
  - A write to a full queue is dropped.
- R8: Opcode 7 captures data bytes, with the count chosen as in R7.
  - Bytes are packed four per word, the first byte most significant, into words readable at 0x80 + 4*i.
  - A final partial word is right-aligned and zero-filled.
  - Receive status bits 13:8 give the number of words stored.
- R9: A program ends at an instruction word of zero, at any opcode other than 1, 2, 3, 7 or 8, or after its eighth instruction. Chip select then goes high.
- R10: Status bit 0 is set from the trigger until the program ends. A trigger written while busy is ignored.
- R11: Flag bit 0 sets when a program ends, and writing 1 to bit 0 clears it. The interrupt output equals the flag AND interrupt-enable bit 0 (offset 0x14).
- R12: Writing control (offset 0x00) with bit 10 set empties the receive buffer. Writing it with bit 11 set empties the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Transfer-done interrupt |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Each kind of internal fault shows up at the ports, most of them within one transfer:
- A wrong instruction pointer, opcode decode or bit counter shows up as a wrong number of SPI clock edges, or a wrong bit pattern on the data-out line, during the same transfer.
- A wrong lock state appears at the next table read-back.
- Bad queue pointers show as wrong data bytes or a wrong full bit after the following transfer.
- Misplaced packing of received bits appears at once in the receive words and the level field.

The sweeps run through several address widths and byte counts 1 to 9, which covers every partial-word position.

// File: rtl/fs_pkg.sv
package fs_pkg;
    localparam logic [31:0] LUT_KEY = 32'h5AF0_5AF0;

    localparam logic [5:0] OP_CMD   = 6'd1;
    localparam logic [5:0] OP_ADDR  = 6'd2;
    localparam logic [5:0] OP_DUMMY = 6'd3;
    localparam logic [5:0] OP_READ  = 6'd7;
    localparam logic [5:0] OP_WRITE = 6'd8;

    // Word offsets of the control registers
    localparam int W_CTRL   = 0;
    localparam int W_TRIG   = 1;
    localparam int W_FADDR  = 2;
    localparam int W_STAT   = 3;
    localparam int W_FLAG   = 4;
    localparam int W_IRQEN  = 5;
    localparam int W_RXSTAT = 6;
    localparam int W_TXDATA = 7;
    localparam int W_KEY    = 8;
    localparam int W_LOCK   = 9;
    localparam int RX_BASE  = 32;
    localparam int LUT_BASE = 64;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] pad;
        logic [7:0] arg;
    } instr_t;

    typedef enum logic [1:0] {S_IDLE, S_DECODE, S_SHIFT, S_FINISH} state_e;
endpackage

// File: rtl/fs_lut_store.sv
module fs_lut_store
    import fs_pkg::*;
#(
    parameter int NSEQ = 16,
    localparam int DEPTH = NSEQ * 4,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          is_key,
    input  logic          is_lock,
    input  logic          is_entry,
    input  logic [IW-1:0] bus_idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   bus_data,
    input  logic [IW-1:0] eng_idx,
    output logic [31:0]   eng_data
);
    logic [31:0] mem [DEPTH];
    logic        armed;
    logic        unlocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            unlocked <= 1'b0;
        end else if (bus_wr) begin
            armed <= is_key && (wdata == LUT_KEY);
            if (is_lock && armed) begin
                if (wdata == 32'd2)      unlocked <= 1'b1;
                else if (wdata == 32'd1) unlocked <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (bus_wr && is_entry && unlocked) begin
            mem[bus_idx] <= wdata;
        end
    end

    assign bus_data = mem[bus_idx];
    assign eng_data = mem[eng_idx];
endmodule

// File: rtl/fs_txq.sv
module fs_txq #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        push,
    input  logic [31:0] din,
    input  logic        pop,
    output logic [31:0] head,
    output logic        full
);
    logic [31:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic do_push, do_pop;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (cnt != '0);
    assign head    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else if (clr) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end
endmodule

// File: rtl/fs_rxbuf.sv
module fs_rxbuf #(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [31:0]   din,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    output logic [LW-1:0] level
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                level <= '0;
        else if (clr)                              level <= '0;
        else if (push && level < LW'(DEPTH))       level <= level + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push && !clr && level < LW'(DEPTH)) mem[level[IW-1:0]] <= din;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fs_engine.sv
module fs_engine
    import fs_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int SEQ_W   = 4,
    parameter int CNT_W   = 8,
    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
    localparam int BIT_W  = CNT_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEQ_W-1:0] start_seq,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic [31:0]      faddr,
    output logic [SEQ_W+1:0] ent_idx,
    input  logic [31:0]      ent_data,
    input  logic [31:0]      tx_head,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [31:0]      rx_word,
    output logic             busy,
    output logic             done,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    state_e state, state_n;
    logic [3:0]       ptr;
    logic [SEQ_W-1:0] seq_r;
    logic [CNT_W-1:0] cnt_r;
    logic [31:0]      shreg;
    logic [BIT_W-1:0] bits_left;
    logic [4:0]       wbit;
    logic [5:0]       op_r;
    logic [DIV_W-1:0] div;
    logic             sck_r, sample;

    instr_t           ins;
    logic [CNT_W-1:0] data_bytes;
    logic [BIT_W-1:0] dec_bits;
    logic             dec_known, dec_end, div_end, fall_ev, last, wend;

    assign ent_idx = {seq_r, ptr[2:1]};
    assign ins     = ptr[0] ? ent_data[31:16] : ent_data[15:0];
    assign data_bytes = (cnt_r != '0) ? cnt_r : CNT_W'(ins.arg);

    always_comb begin
        dec_known = 1'b1;
        dec_bits  = '0;
        case (ins.op)
            OP_CMD:   dec_bits = BIT_W'(8);
            OP_ADDR:  dec_bits = (ins.arg > 8'd32) ? BIT_W'(32) : BIT_W'(ins.arg);
            OP_DUMMY: dec_bits = BIT_W'(ins.arg);
            OP_READ,
            OP_WRITE: dec_bits = BIT_W'({data_bytes, 3'b000});
            default:  dec_known = 1'b0;
        endcase
    end

    assign dec_end = ptr[3] || !dec_known;
    assign div_end = (div == DIV_W'(CLK_DIV - 1));
    assign fall_ev = (state == S_SHIFT) && div_end && sck_r;
    assign last    = (bits_left == BIT_W'(1));
    assign wend    = (wbit == 5'd31);

    // Next-state process
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (start) state_n = S_DECODE;
            S_DECODE: if (dec_end) state_n = S_FINISH;
                      else if (dec_bits != '0) state_n = S_SHIFT;
            S_SHIFT:  if (fall_ev && last) state_n = S_DECODE;
            S_FINISH: state_n = S_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        busy    = (state != S_IDLE);
        done    = (state == S_FINISH);
        cs_n    = !((state == S_DECODE) || (state == S_SHIFT));
        sck     = sck_r;
        mosi    = (state == S_SHIFT) && (op_r != OP_READ) && (op_r != OP_DUMMY) && shreg[31];
        rx_word = {shreg[30:0], sample};
        rx_push = fall_ev && (op_r == OP_READ) && (wend || last);
        tx_pop  = ((state == S_DECODE) && !dec_end && (ins.op == OP_WRITE) && (dec_bits != '0))
               || (fall_ev && (op_r == OP_WRITE) && wend && !last);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0; seq_r <= '0; cnt_r <= '0; shreg <= '0; bits_left <= '0;
            wbit <= '0; op_r <= '0; div <= '0; sck_r <= 1'b0; sample <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    seq_r <= start_seq;
                    cnt_r <= start_cnt;
                    ptr   <= '0;
                end
                S_DECODE: if (!dec_end) begin
                    ptr       <= ptr + 1'b1;
                    op_r      <= ins.op;
                    bits_left <= dec_bits;
                    wbit      <= '0;
                    div       <= '0;
                    sck_r     <= 1'b0;
                    case (ins.op)
                        OP_CMD:   shreg <= {ins.arg, 24'h0};
                        OP_ADDR:  shreg <= faddr << (6'd32 - dec_bits[5:0]);
                        OP_WRITE: shreg <= tx_head;
                        default:  shreg <= '0;
                    endcase
                end
                S_SHIFT: if (div_end) begin
                    div <= '0;
                    if (!sck_r) begin
                        sck_r  <= 1'b1;
                        sample <= miso;
                    end else begin
                        sck_r     <= 1'b0;
                        bits_left <= bits_left - 1'b1;
                        wbit      <= wbit + 1'b1;
                        if (wend && op_r == OP_WRITE)     shreg <= tx_head;
                        else if (wend && op_r == OP_READ) shreg <= '0;
                        else                              shreg <= {shreg[30:0], sample};
                    end
                end else begin
                    div <= div + 1'b1;
                end
                S_FINISH: sck_r <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fs_top.sv
module fs_top
    import fs_pkg::*;
#(
    parameter int NSEQ     = 16,
    parameter int TX_WORDS = 16,
    parameter int RX_WORDS = 32,
    parameter int CLK_DIV  = 2,
    parameter int AW       = 10,
    localparam int SEQ_W   = $clog2(NSEQ),
    localparam int LUT_IW  = SEQ_W + 2,
    localparam int RX_IW   = $clog2(RX_WORDS),
    localparam int RX_LW   = $clog2(RX_WORDS + 1),
    localparam int WW      = AW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq,
    output logic          spi_sck,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    logic [WW-1:0] word;
    logic is_rx, is_lut, start, busy, done, tx_pop, tx_full, rx_push;
    logic [31:0] faddr, lut_bus, lut_eng, tx_head, rx_word, rx_rd;
    logic [LUT_IW-1:0] ent_idx;
    logic [RX_LW-1:0]  rx_level;
    logic done_flag, irq_en;

    assign word   = bus_addr[AW-1:2];
    assign is_rx  = (int'(word) >= RX_BASE)  && (int'(word) < RX_BASE + RX_WORDS);
    assign is_lut = (int'(word) >= LUT_BASE) && (int'(word) < LUT_BASE + NSEQ * 4);
    assign start  = bus_wr && (int'(word) == W_TRIG) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            faddr <= '0; irq_en <= 1'b0; done_flag <= 1'b0;
        end else begin
            if (bus_wr && int'(word) == W_FADDR) faddr  <= bus_wdata;
            if (bus_wr && int'(word) == W_IRQEN) irq_en <= bus_wdata[0];
            if (done) done_flag <= 1'b1;
            else if (bus_wr && int'(word) == W_FLAG && bus_wdata[0]) done_flag <= 1'b0;
        end
    end

    assign irq = done_flag && irq_en;

    always_comb begin
        bus_rdata = '0;
        if (is_rx)       bus_rdata = rx_rd;
        else if (is_lut) bus_rdata = lut_bus;
        else case (int'(word))
            W_FADDR:  bus_rdata = faddr;
            W_STAT:   bus_rdata = {4'b0, tx_full, 26'b0, busy};
            W_FLAG:   bus_rdata = {31'b0, done_flag};
            W_IRQEN:  bus_rdata = {31'b0, irq_en};
            W_RXSTAT: bus_rdata = 32'(rx_level) << 8;
            default:  bus_rdata = '0;
        endcase
    end

    fs_lut_store #(.NSEQ(NSEQ)) u_lut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .is_key(int'(word) == W_KEY), .is_lock(int'(word) == W_LOCK), .is_entry(is_lut),
        .bus_idx(LUT_IW'(int'(word) - LUT_BASE)), .wdata(bus_wdata), .bus_data(lut_bus),
        .eng_idx(ent_idx), .eng_data(lut_eng)
    );

    fs_txq #(.DEPTH(TX_WORDS)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .clr(bus_wr && int'(word) == W_CTRL && bus_wdata[11]),
        .push(bus_wr && int'(word) == W_TXDATA), .din(bus_wdata),
        .pop(tx_pop), .head(tx_head), .full(tx_full)
    );

    fs_rxbuf #(.DEPTH(RX_WORDS)) u_rxb (
        .clk(clk), .rst_n(rst_n),
        .clr(bus_wr && int'(word) == W_CTRL && bus_wdata[10]),
        .push(rx_push), .din(rx_word),
        .rd_idx(RX_IW'(int'(word) - RX_BASE)), .rd_data(rx_rd), .level(rx_level)
    );

    fs_engine #(.CLK_DIV(CLK_DIV), .SEQ_W(SEQ_W), .CNT_W(8)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_seq(bus_wdata[24 +: SEQ_W]), .start_cnt(bus_wdata[7:0]),
        .faddr(faddr), .ent_idx(ent_idx), .ent_data(lut_eng),
        .tx_head(tx_head), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .busy(busy), .done(done), .sck(spi_sck), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .miso(spi_miso)
    );
endmodule

// File: rtl/fs_chk.sv
module fs_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done_flag,
    input logic irq,
    input logic spi_cs_n,
    input logic spi_sck
);
    p_sck_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_cs_within_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    p_flag_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_cs_n) && busy) |=> done_flag);

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);
endmodule

bind fs_top fs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done_flag(done_flag),
    .irq(irq), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/sim_fs_top.sv
`timescale 1ns/1ps
module sim_fs_top;
    localparam int DIV = 2;
    localparam logic [9:0] A_CTRL = 10'h000, A_TRIG = 10'h004, A_FADDR = 10'h008,
        A_STAT = 10'h00C, A_FLAG = 10'h010, A_IRQEN = 10'h014, A_RXST = 10'h018,
        A_TX = 10'h01C, A_KEY = 10'h020, A_LOCK = 10'h024, A_RX = 10'h080, A_LUT = 10'h100;

    logic clk = 0, rst_n = 0, bus_wr = 0;
    logic [9:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic irq, spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int n_chk = 0, n_bad = 0, cyc = 0, rcnt = 0, ecnt = 0;
    logic [1023:0] mlog, eexp;
    realtime t_last = 0, t_per = 0;

    always #10 clk = ~clk;

    fs_top #(.CLK_DIV(DIV)) u0 (.*);

    function automatic logic sbit(input int i);
        logic [7:0] b;
        b = 8'((i / 8) * 37 + 5);
        return b[7 - (i % 8)];
    endfunction
    function automatic logic [7:0] sbyte(input int k);
        return 8'(k * 37 + 5);
    endfunction
    function automatic logic [31:0] tw(input int j);
        return 32'hA500_0000 + 32'(j) * 32'h0103_0507;
    endfunction
    function automatic logic [15:0] ins(input logic [5:0] op, input logic [7:0] arg);
        return {op, 2'b00, arg};
    endfunction

    assign spi_miso = sbit(rcnt);
    always @(posedge spi_sck) begin
        mlog[rcnt] = spi_mosi;
        rcnt = rcnt + 1;
        t_per = $realtime - t_last;
        t_last = $realtime;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 180000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<180000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask
    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask
    task automatic prog(input int s, input logic [15:0] i0, i1, i2, i3, i4, i5, i6, i7);
        wr(A_KEY, 32'h5AF0_5AF0); wr(A_LOCK, 2);
        wr(A_LUT + 10'(16 * s),      {i1, i0});
        wr(A_LUT + 10'(16 * s + 4),  {i3, i2});
        wr(A_LUT + 10'(16 * s + 8),  {i5, i4});
        wr(A_LUT + 10'(16 * s + 12), {i7, i6});
        wr(A_KEY, 32'h5AF0_5AF0); wr(A_LOCK, 1);
    endtask
    task automatic run(input int s, input int cnt);
        logic [31:0] st;
        rcnt = 0; ecnt = 0; mlog = '0; eexp = '0;
        wr(A_TRIG, (32'(s) << 24) | 32'(cnt));
        for (int k = 0; k < 20000; k++) begin
            rd(A_STAT, st);
            if (!st[0]) break;
        end
    endtask
    task automatic epush(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin eexp[ecnt] = v[i]; ecnt++; end
    endtask
    task automatic cmp_wire(input string tag);
        logic [1023:0] m;
        m = '0;
        for (int i = 0; i < ecnt; i++) m[i] = 1'b1;
        chk(rcnt == ecnt, {tag, " bit count"}, 64'(rcnt), 64'(ecnt));
        chk((mlog & m) == (eexp & m), {tag, " wire bits"}, mlog[63:0], eexp[63:0]);
    endtask

    initial begin
        logic [31:0] d, e, fa;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(A_STAT, d);  chk(d == 0, "R1 status", d, 0);
        rd(A_FLAG, d);  chk(d == 0, "R1 flag", d, 0);
        rd(A_RXST, d);  chk(d == 0, "R1 rx level", d, 0);
        rd(A_LUT + 10'h3C, d); chk(d == 0, "R1 table word", d, 0);
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && irq === 1'b0, "R1 pins",
            {spi_cs_n, spi_sck, irq}, 3'b100);

        // R2 lock behaviour
        wr(A_LUT, 32'h1111_2222); rd(A_LUT, d); chk(d == 0, "R2 locked write", d, 0);
        wr(A_KEY, 32'h5AF0_5AF0); wr(A_FADDR, 0); wr(A_LOCK, 2);
        wr(A_LUT, 32'h1111_2222); rd(A_LUT, d); chk(d == 0, "R2 key cancelled", d, 0);
        wr(A_KEY, 32'h5AF0_5AF1); wr(A_LOCK, 2);
        wr(A_LUT, 32'h1111_2222); rd(A_LUT, d); chk(d == 0, "R2 wrong key", d, 0);
        wr(A_KEY, 32'h5AF0_5AF0); wr(A_LOCK, 2);
        wr(A_LUT, 32'h1111_2222); rd(A_LUT, d); chk(d == 32'h1111_2222, "R2 unlocked write", d, 32'h1111_2222);
        wr(A_KEY, 32'h5AF0_5AF0); wr(A_LOCK, 1);
        wr(A_LUT, 32'h3333_4444); rd(A_LUT, d); chk(d == 32'h1111_2222, "R2 relocked", d, 32'h1111_2222);

        // R4 R9 single command, zero word ends
        prog(1, ins(1, 8'h06), 0, 0, 0, 0, 0, 0, 0);
        run(1, 0);
        epush(32'h06, 8); cmp_wire("R4 cmd");
        chk(t_per == 2.0 * DIV * 20.0, "R4 clock period", 64'(int'(t_per)), 64'(2 * DIV * 20));
        chk(spi_cs_n === 1'b1, "R9 cs released", spi_cs_n, 1);

        // R11 flag and interrupt
        rd(A_FLAG, d); chk(d == 1, "R11 flag set", d, 1);
        chk(irq === 1'b0, "R11 irq masked", irq, 0);
        wr(A_IRQEN, 1); chk(irq === 1'b1, "R11 irq on", irq, 1);
        wr(A_FLAG, 0); rd(A_FLAG, d); chk(d == 1, "R11 write zero keeps", d, 1);
        wr(A_FLAG, 1); rd(A_FLAG, d); chk(d == 0, "R11 w1c", d, 0);
        chk(irq === 1'b0, "R11 irq off", irq, 0);

        // R5 address widths sweep
        for (int n = 8; n <= 32; n += 8) begin
            prog(4, ins(1, 8'h0B), ins(2, 8'(n)), 0, 0, 0, 0, 0, 0);
            for (int a = 0; a < 2; a++) begin
                fa = 32'h89AB_CDEF ^ (32'(a) * 32'h5A5A_5A5A) ^ 32'(n);
                wr(A_FADDR, fa);
                run(4, 0);
                epush(32'h0B, 8); epush(fa, n);
                cmp_wire($sformatf("R5 addr n=%0d", n));
            end
        end

        // R3 R7 write sweep over byte counts
        prog(2, ins(1, 8'h02), ins(2, 8'd24), ins(8, 8'd0), 0, 0, 0, 0, 0);
        wr(A_FADDR, 32'h0012_3456);
        for (int c = 1; c <= 9; c++) begin
            wr(A_CTRL, 32'h800);
            for (int j = 0; j < 3; j++) wr(A_TX, tw(j));
            run(2, c);
            epush(32'h02, 8); epush(32'h12_3456, 24);
            for (int k = 0; k < c; k++) epush(tw(k / 4) >> (24 - 8 * (k % 4)), 8);
            cmp_wire($sformatf("R7 write c=%0d", c));
        end

        // R8 read sweep
        prog(3, ins(1, 8'h03), ins(2, 8'd24), ins(7, 8'd0), 0, 0, 0, 0, 0);
        for (int c = 1; c <= 9; c++) begin
            wr(A_CTRL, 32'h400);
            run(3, c);
            rd(A_RXST, d); chk(d == 32'((c + 3) / 4) << 8, $sformatf("R8 level c=%0d", c), d, 32'((c + 3) / 4) << 8);
            for (int w = 0; w < (c + 3) / 4; w++) begin
                e = 0;
                for (int j = 0; j < 4 && 4 * w + j < c; j++) e = (e << 8) | 32'(sbyte(4 + 4 * w + j));
                rd(A_RX + 10'(4 * w), d);
                chk(d == e, $sformatf("R8 word c=%0d w=%0d", c, w), d, e);
            end
        end

        // R12 receive clear
        wr(A_CTRL, 32'h400); rd(A_RXST, d); chk(d == 0, "R12 rx cleared", d, 0);

        // R6 dummy cycles then read by operand count
        prog(5, ins(1, 8'h0B), ins(3, 8'd4), ins(7, 8'd2), 0, 0, 0, 0, 0);
        run(5, 0);
        epush(32'h0B, 8); epush(0, 20); cmp_wire("R6 dummy");
        e = 0;
        for (int i = 12; i < 28; i++) e = (e << 1) | 32'(sbit(i));
        rd(A_RX, d); chk(d == e, "R6 data after dummy", d, e);

        // R9 eight instructions, and unknown opcode ends
        prog(6, ins(1, 8'h11), ins(1, 8'h22), ins(1, 8'h33), ins(1, 8'h44),
                ins(1, 8'h55), ins(1, 8'h66), ins(1, 8'h77), ins(1, 8'h88));
        run(6, 0);
        for (int k = 1; k <= 8; k++) epush(32'(k * 17), 8);
        cmp_wire("R9 eight steps");
        prog(7, ins(1, 8'h9F), ins(5, 8'h00), ins(1, 8'h01), 0, 0, 0, 0, 0);
        run(7, 0);
        epush(32'h9F, 8); cmp_wire("R9 unknown opcode");

        // R10 busy and trigger while busy
        wr(A_TRIG, 32'h0100_0000);
        rd(A_STAT, d); chk(d[0] == 1'b1, "R10 busy", d, 1);
        rcnt = 0; mlog = '0;
        wr(A_TRIG, 32'h0600_0000);
        run(1, 0);
        chk(rcnt <= 8, "R10 trigger ignored", 64'(rcnt), 8);
        rd(A_STAT, d); chk(d[0] == 1'b0, "R10 idle", d, 0);

        // R12 transmit clear
        wr(A_TX, 32'hFFFF_FFFF); wr(A_TX, 32'hEEEE_EEEE); wr(A_CTRL, 32'h800);
        wr(A_TX, 32'hC3A5_0F96);
        prog(8, ins(8, 8'd4), 0, 0, 0, 0, 0, 0, 0);
        run(8, 0);
        epush(32'hC3A5_0F96, 32); cmp_wire("R12 tx cleared");

        // R7 full flag and dropped write
        wr(A_CTRL, 32'h800);
        for (int j = 0; j < 16; j++) wr(A_TX, tw(j));
        rd(A_STAT, d); chk(d[27] == 1'b1, "R7 full bit", d, 32'h0800_0000);
        wr(A_TX, 32'hDEAD_BEEF);
        prog(8, ins(8, 8'd64), 0, 0, 0, 0, 0, 0, 0);
        run(8, 0);
        for (int j = 0; j < 16; j++) epush(tw(j), 32);
        cmp_wire("R7 dropped when full");
        rd(A_STAT, d); chk(d[27] == 1'b0, "R7 full cleared", d, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule